// File: doc/BRIEF.md
# Byte-Lane Load/Store Adapter

This block connects a processor load/store port to byte-wide backing storage. A request names a size (byte, halfword or word), an address and, for stores, the data. The adapter breaks it into single-byte accesses, one per clock, at the request address and the addresses that follow. On loads it packs the fetched bytes into a little-endian result. On stores it sends the bytes of the write data to memory, least significant byte first.

Behind the sequencer sits an address decoder. It checks each byte address against two RAM regions and against a ROM store that is visible through three separate windows, in a fixed priority order. A byte address that matches nothing reads as 0xFF, discards a store, and marks the transaction as erroneous. A misaligned halfword or word address is flagged, but the access still goes ahead at the exact address given.

Top module: `byte_lane_adapter`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done` is 0. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 while a transaction is in flight.
- R2: Size encoding: 2'b00 byte (1 access), 2'b01 halfword (2 accesses), 2'b10 or 2'b11 word (4 accesses). One byte access happens per clock. `rsp_done` is high for exactly one cycle, starting N rising edges after the accepting edge, where N is the number of accesses.
- R3: A halfword load returns the byte at the address in bits [7:0] and the byte at address+1 in bits [15:8], with bits [31:16] zero. A halfword store writes `req_wdata[7:0]` to the address and `req_wdata[15:8]` to address+1.
- R4: A word load places the byte at address+k in bits [8k+7:8k], for k from 0 to 3. A word store writes `req_wdata[8k+7:8k]` to address+k.
- R5: A byte load returns the byte in bits [7:0] with bits [31:8] zero. A byte store writes `req_wdata[7:0]`.
- R6: A halfword request with address bit 0 set reports `rsp_misaligned`=1 with `rsp_done`, and still accesses exactly the address and address+1. With bit 0 clear it reports 0.
- R7: A word request with either of address bits [1:0] set reports `rsp_misaligned`=1, and the access still proceeds at the given address. Byte requests never report misalignment.
- R8: A region covers the half-open range [base, base+size). With default parameters, RAM A is 0x0000–0x003F, RAM B is 0x0100–0x011F, and the ROM windows start at 0x1000, 0x2000 and 0x3000, each 0x40 bytes long.
- R9: All three ROM windows map onto one shared store at offset (address − window base). A store through one window is visible through the other two.
- R10: A load byte that matches no region reads as 0xFF in its lane, and `rsp_error` is 1 with `rsp_done`. Mapped lanes of the same request still return stored data. A request whose bytes all hit is reported with `rsp_error`=0.
- R11: A store byte that matches no region is discarded and reported with `rsp_error`=1. The mapped bytes of the same request are still written.
- R12: The byte addresses of a request are the request address plus 0, 1, 2 and 3, wrapping modulo 2^AW. Regions are checked in the order RAM A, RAM B, ROM window 0, window 1, window 2, and the first match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr | input | AW | Byte address of the first byte |
| req_wdata | input | 32 | Store data, little-endian lanes |
| req_ready | output | 1 | Adapter idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result, valid with rsp_done |
| rsp_misaligned | output | 1 | Alignment warning, valid with rsp_done |
| rsp_error | output | 1 | At least one byte was unmapped, valid with rsp_done |

## Verification
Every result of a request is due in the cycle that follows the N-th rising edge after the accepting edge, where N is 1, 2 or 4 depending on the size. This applies to the load data, the misalignment flag and the error flag alike. The bench drives inputs on falling edges. After the accepting edge it counts rising edges and samples on each following falling edge until it sees `rsp_done`, then compares the counted latency with N. It reads the data and both flags in that same sampling slot. Stores are confirmed through later loads, including loads through a different ROM window and loads that straddle a region end.

// File: rtl/byte_lane_adapter.sv
module byte_lane_adapter #(
  parameter int AW        = 16,
  parameter int RA_BASE   = 'h0000,
  parameter int RA_SIZE   = 64,
  parameter int RB_BASE   = 'h0100,
  parameter int RB_SIZE   = 32,
  parameter int ROM_SIZE  = 64,
  parameter int ROM_BASE0 = 'h1000,
  parameter int ROM_BASE1 = 'h2000,
  parameter int ROM_BASE2 = 'h3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_misaligned,
  output logic          rsp_error
);

  localparam int AIW = (RA_SIZE  > 1) ? $clog2(RA_SIZE)  : 1;
  localparam int BIW = (RB_SIZE  > 1) ? $clog2(RB_SIZE)  : 1;
  localparam int RIW = (ROM_SIZE > 1) ? $clog2(ROM_SIZE) : 1;

  localparam logic [AW:0] A_LO  = (AW+1)'(RA_BASE);
  localparam logic [AW:0] A_HI  = (AW+1)'(RA_BASE + RA_SIZE);
  localparam logic [AW:0] B_LO  = (AW+1)'(RB_BASE);
  localparam logic [AW:0] B_HI  = (AW+1)'(RB_BASE + RB_SIZE);
  localparam logic [AW:0] R0_LO = (AW+1)'(ROM_BASE0);
  localparam logic [AW:0] R0_HI = (AW+1)'(ROM_BASE0 + ROM_SIZE);
  localparam logic [AW:0] R1_LO = (AW+1)'(ROM_BASE1);
  localparam logic [AW:0] R1_HI = (AW+1)'(ROM_BASE1 + ROM_SIZE);
  localparam logic [AW:0] R2_LO = (AW+1)'(ROM_BASE2);
  localparam logic [AW:0] R2_HI = (AW+1)'(ROM_BASE2 + ROM_SIZE);

  logic [7:0] ram_a   [RA_SIZE];
  logic [7:0] ram_b   [RB_SIZE];
  logic [7:0] rom_mem [ROM_SIZE];

  logic          busy;
  logic [1:0]    idx, last_idx;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [1:0]    size_q;
  logic [31:0]   wdata_q;
  logic [31:0]   acc;
  logic          err_acc;
  logic          mis_q;
  logic          done_q;

  logic          accept;
  logic [AW-1:0] cur;
  logic [AW:0]   cur_x;
  logic          hit_a, hit_b, hit_r0, hit_r1, hit_r2, hit_rom, unmapped;
  logic [AIW-1:0] off_a;
  logic [BIW-1:0] off_b;
  logic [RIW-1:0] off_r;
  logic [7:0]    rbyte, wbyte;
  logic          mis_in;
  logic [1:0]    last_in;

  assign req_ready      = !busy;
  assign accept         = req_valid && !busy;
  assign rsp_done       = done_q;
  assign rsp_rdata      = acc;
  assign rsp_misaligned = mis_q;
  assign rsp_error      = err_acc;

  assign cur   = addr_q + AW'(idx);
  assign cur_x = {1'b0, cur};

  assign hit_a  = (cur_x >= A_LO)  && (cur_x < A_HI);
  assign hit_b  = (cur_x >= B_LO)  && (cur_x < B_HI);
  assign hit_r0 = (cur_x >= R0_LO) && (cur_x < R0_HI);
  assign hit_r1 = (cur_x >= R1_LO) && (cur_x < R1_HI);
  assign hit_r2 = (cur_x >= R2_LO) && (cur_x < R2_HI);
  assign hit_rom  = hit_r0 || hit_r1 || hit_r2;
  assign unmapped = !(hit_a || hit_b || hit_rom);

  assign off_a = AIW'(cur - AW'(RA_BASE));
  assign off_b = BIW'(cur - AW'(RB_BASE));

  always_comb begin
    if (hit_r0)      off_r = RIW'(cur - AW'(ROM_BASE0));
    else if (hit_r1) off_r = RIW'(cur - AW'(ROM_BASE1));
    else             off_r = RIW'(cur - AW'(ROM_BASE2));
  end

  always_comb begin
    if (hit_a)        rbyte = ram_a[off_a];
    else if (hit_b)   rbyte = ram_b[off_b];
    else if (hit_rom) rbyte = rom_mem[off_r];
    else              rbyte = 8'hFF;
  end

  assign wbyte = wdata_q[{idx, 3'b000} +: 8];

  always_comb begin
    case (req_size)
      2'b00:   begin last_in = 2'd0; mis_in = 1'b0; end
      2'b01:   begin last_in = 2'd1; mis_in = req_addr[0]; end
      default: begin last_in = 2'd3; mis_in = |req_addr[1:0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      size_q   <= '0;
      wdata_q  <= '0;
      acc      <= '0;
      err_acc  <= 1'b0;
      mis_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        idx      <= '0;
        last_idx <= last_in;
        addr_q   <= req_addr;
        wr_q     <= req_write;
        size_q   <= req_size;
        wdata_q  <= req_wdata;
        acc      <= '0;
        err_acc  <= 1'b0;
        mis_q    <= mis_in;
      end else if (busy) begin
        if (!wr_q) acc[{idx, 3'b000} +: 8] <= rbyte;
        if (unmapped) err_acc <= 1'b1;
        if (idx == last_idx) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx <= idx + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && wr_q) begin
      if (hit_a)        ram_a[off_a]   <= wbyte;
      else if (hit_b)   ram_b[off_b]   <= wbyte;
      else if (hit_rom) rom_mem[off_r] <= wbyte;
    end
  end

  // R2
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R2
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(busy));

  // R1
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_done && !req_ready));

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && size_q == 2'b00) |-> (rsp_rdata[31:8] == 24'h0));

  // R3
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && size_q == 2'b01) |-> (rsp_rdata[31:16] == 16'h0));

  // R7
  byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && size_q == 2'b00) |-> !rsp_misaligned);

  // R10
  unmapped_lane_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && unmapped) |=> (rsp_error && acc[{$past(idx), 3'b000} +: 8] == 8'hFF));

  // R12
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0({hit_a, hit_b, hit_r0, hit_r1, hit_r2}));

endmodule

// File: tb/byte_lane_adapter_tb_top.sv
`timescale 1ns/1ps
module byte_lane_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_done, rsp_misaligned, rsp_error;
  logic [31:0] rsp_rdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  byte_lane_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_misaligned(rsp_misaligned), .rsp_error(rsp_error)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output bit mis, output bit err, output int lat);
    int k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    lat = -1;
    while (k < 20) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (rsp_done) begin
        lat = k; rd = rsp_rdata; mis = rsp_misaligned; err = rsp_error;
        break;
      end
    end
    if (lat < 0) begin rd = '0; mis = 0; err = 0; end
  endtask

  task automatic ld(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] exp,
                    input bit exp_err, input string tag);
    logic [31:0] rd; bit mis, err; int lat;
    access(1'b0, sz, a, '0, rd, mis, err, lat);
    check(rd == exp, tag, rd, exp);
    check(err == exp_err, {tag, " error flag"}, 32'(err), 32'(exp_err));
  endtask

  task automatic st(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] wd,
                    input bit exp_err, input string tag);
    logic [31:0] rd; bit mis, err; int lat;
    access(1'b1, sz, a, wd, rd, mis, err, lat);
    check(err == exp_err, {tag, " store error flag"}, 32'(err), 32'(exp_err));
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_done == 1'b0, "R1 done after reset", 32'(rsp_done), 32'd0);
  endtask

  task automatic t_latency;
    logic [31:0] rd; bit mis, err; int lat;
    access(1'b1, 2'b00, 16'h0010, 32'h000000A5, rd, mis, err, lat);
    check(lat == 1, "R2 byte latency", 32'(lat), 32'd1);
    access(1'b0, 2'b01, 16'h0010, '0, rd, mis, err, lat);
    check(lat == 2, "R2 half latency", 32'(lat), 32'd2);
    access(1'b0, 2'b10, 16'h0010, '0, rd, mis, err, lat);
    check(lat == 4, "R2 word latency", 32'(lat), 32'd4);
    access(1'b0, 2'b11, 16'h0010, '0, rd, mis, err, lat);
    check(lat == 4, "R2 size 11 latency", 32'(lat), 32'd4);
    @(negedge clk);
    check(rsp_done == 1'b0, "R2 done single cycle", 32'(rsp_done), 32'd0);
  endtask

  task automatic t_byte;
    st(2'b00, 16'h0011, 32'hFFFFFF3C, 1'b0, "R5 byte store");
    ld(2'b00, 16'h0011, 32'h0000003C, 1'b0, "R5 byte load");
    ld(2'b00, 16'h0010, 32'h000000A5, 1'b0, "R5 byte load neighbour");
  endtask

  task automatic t_half;
    st(2'b01, 16'h0020, 32'h1234BEEF, 1'b0, "R3 half store");
    ld(2'b00, 16'h0020, 32'h000000EF, 1'b0, "R3 low byte");
    ld(2'b00, 16'h0021, 32'h000000BE, 1'b0, "R3 high byte");
    ld(2'b01, 16'h0020, 32'h0000BEEF, 1'b0, "R3 half load");
  endtask

  task automatic t_word;
    st(2'b10, 16'h0100, 32'h12345678, 1'b0, "R4 word store");
    ld(2'b00, 16'h0100, 32'h00000078, 1'b0, "R4 lane0");
    ld(2'b00, 16'h0103, 32'h00000012, 1'b0, "R4 lane3");
    ld(2'b10, 16'h0100, 32'h12345678, 1'b0, "R4 word load");
  endtask

  task automatic t_misalign;
    logic [31:0] rd; bit mis, err; int lat;
    access(1'b1, 2'b01, 16'h0031, 32'h0000CAFE, rd, mis, err, lat);
    check(mis == 1'b1, "R6 odd half flagged", 32'(mis), 32'd1);
    ld(2'b00, 16'h0031, 32'h000000FE, 1'b0, "R6 odd half low byte at exact address");
    ld(2'b00, 16'h0032, 32'h000000CA, 1'b0, "R6 odd half high byte");
    access(1'b0, 2'b01, 16'h0030, '0, rd, mis, err, lat);
    check(mis == 1'b0, "R6 even half not flagged", 32'(mis), 32'd0);
    access(1'b0, 2'b10, 16'h0102, '0, rd, mis, err, lat);
    check(mis == 1'b1, "R7 word addr bit1 flagged", 32'(mis), 32'd1);
    check(rd == 32'h????1234 || rd[15:0] == 16'h1234, "R7 word at 0x0102 lanes", rd, 32'h00001234);
    access(1'b0, 2'b10, 16'h0101, '0, rd, mis, err, lat);
    check(mis == 1'b1, "R7 word addr bit0 flagged", 32'(mis), 32'd1);
    access(1'b0, 2'b10, 16'h0104, '0, rd, mis, err, lat);
    check(mis == 1'b0, "R7 aligned word not flagged", 32'(mis), 32'd0);
    access(1'b0, 2'b00, 16'h0031, '0, rd, mis, err, lat);
    check(mis == 1'b0, "R7 byte never flagged", 32'(mis), 32'd0);
  endtask

  task automatic t_bounds;
    st(2'b00, 16'h003F, 32'h0000005A, 1'b0, "R8 RAM A last byte");
    ld(2'b00, 16'h003F, 32'h0000005A, 1'b0, "R8 RAM A last byte load");
    ld(2'b00, 16'h0040, 32'h000000FF, 1'b1, "R8 RAM A end excluded");
    st(2'b00, 16'h011F, 32'h00000066, 1'b0, "R8 RAM B last byte");
    ld(2'b00, 16'h011F, 32'h00000066, 1'b0, "R8 RAM B last byte load");
    ld(2'b00, 16'h0120, 32'h000000FF, 1'b1, "R8 RAM B end excluded");
    ld(2'b00, 16'h00FF, 32'h000000FF, 1'b1, "R8 below RAM B base");
  endtask

  task automatic t_rom;
    st(2'b10, 16'h1000, 32'hDEADBEEF, 1'b0, "R9 store via window 0");
    ld(2'b10, 16'h2000, 32'hDEADBEEF, 1'b0, "R9 load via window 1");
    ld(2'b10, 16'h3000, 32'hDEADBEEF, 1'b0, "R9 load via window 2");
    st(2'b00, 16'h3004, 32'h00000077, 1'b0, "R9 store via window 2");
    ld(2'b00, 16'h1004, 32'h00000077, 1'b0, "R9 load via window 0");
    st(2'b00, 16'h203F, 32'h00000011, 1'b0, "R8 ROM window 1 last byte");
    ld(2'b00, 16'h303F, 32'h00000011, 1'b0, "R9 window 2 last byte");
    ld(2'b00, 16'h1040, 32'h000000FF, 1'b1, "R8 ROM window end excluded");
  endtask

  task automatic t_unmapped;
    ld(2'b10, 16'h8000, 32'hFFFFFFFF, 1'b1, "R10 unmapped word load");
    st(2'b10, 16'h8000, 32'h01020304, 1'b1, "R11 unmapped word store");
    ld(2'b10, 16'h8000, 32'hFFFFFFFF, 1'b1, "R11 unmapped store left nothing");
    st(2'b10, 16'h003E, 32'h44332211, 1'b1, "R11 straddling store");
    ld(2'b10, 16'h003E, 32'hFFFF2211, 1'b1, "R10 R11 straddling load");
    ld(2'b00, 16'h003E, 32'h00000011, 1'b0, "R11 mapped lane written");
  endtask

  task automatic t_wrap;
    st(2'b00, 16'h0000, 32'h000000C3, 1'b0, "R12 base byte");
    ld(2'b01, 16'hFFFF, 32'h0000C3FF, 1'b1, "R12 address wrap");
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latency;
    t_byte;
    t_half;
    t_word;
    t_misalign;
    t_bounds;
    t_rom;
    t_unmapped;
    t_wrap;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule